// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block sits beside a processor's bus and inspects every cycle it issues. Two comparator channels each hold a condition. The condition covers the address-space identifier, a masked address, the cycle class (fetch or data), the direction and the operand size. The second channel can also require a masked match on the bus data. When the programmed conditions are met, the block drives a break request towards the exception logic.

For instruction fetches, a channel can fire immediately on the matching fetch, which is before the instruction executes. It can instead wait for the instruction-complete strobe that follows the fetch and fire one cycle later, which is after the instruction executes. A control register selects one of two modes. In independent mode either channel triggers a break. In sequential mode a channel-A event only arms the block, and a break needs a later channel-B event. The control register also enables the data comparison.

Software programs the block through a simple register write port. The selected register changes on the clock edge of the write.

Top module: `brk_watch`

## Requirements
- R1: After reset every register reads as zero and `brk_req` stays low. This holds even while reset is held and for any bus traffic, because a cycle-class field of 00 never matches.
- R2: Register select codes are: 0 control, 1..4 channel A (ASID, address, mask code, condition), 5..8 channel B (same order), 9 channel B data, 10 channel B data mask. A write changes the register at the clock edge, so a bus cycle in the same cycle as the write is judged with the old value.
- R3: A channel matches only on a valid cycle whose 8-bit `bus_asid` equals that channel's ASID register.
- R4: Mask code 00 compares all 32 address bits. Code 01 leaves out bits [9:0]. Code 10 leaves out bits [11:0]. Code 11 compares all bits.
- R5: The condition register has these fields. Bits [5:4] give the class (01 fetch, 10 data) and must equal `bus_kind`. Bits [3:2] give the direction (01 read, 10 write) and must equal `bus_dir`. Bits [1:0] give the size: 00 means any size, otherwise it must equal `bus_size` (01 byte, 10 word, 11 long). Class or direction codes 00 and 11 never match.
- R6: When control bit 1 is set and the cycle is a data access, channel B also requires a data match. A data-mask bit of 1 leaves that data bit out of the comparison. Only the low 8 bits are compared for byte cycles and only the low 16 bits for word cycles.
- R7: A pre-execution event drives `brk_req` in the same cycle as the matching bus cycle. Data-class conditions always behave as pre-execution.
- R8: When condition bit 6 is set and the class is fetch, the event instead occurs one cycle after the first `insn_done` pulse that comes in a cycle after the match.
- R9: In independent mode (control bit 0 clear), an event on either channel raises `brk_req`.
- R10: In sequential mode (control bit 0 set), a channel-A event sets an arm flag and raises no break. A channel-B event raises `brk_req` only if the flag is already set, and otherwise it is ignored.
- R11: The arm flag is cleared by any write to the control register, which takes first priority. It is also cleared by a sequential-mode break. A channel-A event in the same cycle as a break does not re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Bus cycle address |
| bus_asid | input | 8 | Address-space identifier of the cycle |
| bus_kind | input | 2 | Cycle class: 01 fetch, 10 data |
| bus_dir | input | 2 | Direction: 01 read, 10 write |
| bus_size | input | 2 | Size: 01 byte, 10 word, 11 long |
| bus_data | input | 32 | Bus data |
| insn_done | input | 1 | Instruction-complete strobe |
| brk_req | output | 1 | Break request |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, an 8-bit ASID, and mask codes that drop 10 and 12 low address bits. With these values the block-sized address windows and the 16-bit word data lanes fall inside the random stimulus. The random addresses are drawn near the programmed ones with low bits flipped, so both sides of every mask boundary occur. The `insn_done` strobes are scattered randomly, so post-execution breaks, arm/clear ordering and same-cycle collisions between the channels all occur.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_FETCH = 2'b01,
    KIND_DATA  = 2'b10,
    KIND_RSV   = 2'b11
  } kind_e;

  localparam logic [1:0] DIR_RD  = 2'b01;
  localparam logic [1:0] DIR_WR  = 2'b10;
  localparam logic [1:0] SZ_ANY  = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  localparam int CTRL_SEQ_BIT = 0;
  localparam int CTRL_DBE_BIT = 1;

  localparam int SEL_CTRL    = 0;
  localparam int SEL_CHAN0   = 1;
  localparam int CHAN_STRIDE = 4;
  localparam int OFS_ASID    = 0;
  localparam int OFS_ADDR    = 1;
  localparam int OFS_MASK    = 2;
  localparam int OFS_COND    = 3;
  localparam int SEL_BDATA   = 9;
  localparam int SEL_BDMASK  = 10;

  // condition register layout: [6] post, [5:4] class, [3:2] dir, [1:0] size
  typedef struct packed {
    logic       post;
    logic [1:0] kind;
    logic [1:0] dir;
    logic [1:0] size;
  } cond_t;
endpackage

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int IW         = 8,
  parameter int SELW       = 4,
  parameter int BASE       = 1,
  parameter bit HAS_DATA   = 1'b0,
  parameter int MASK1_LSBS = 10,
  parameter int MASK2_LSBS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            dbe,
  input  logic            bus_valid,
  input  logic [AW-1:0]   bus_addr,
  input  logic [IW-1:0]   bus_asid,
  input  logic [1:0]      bus_kind,
  input  logic [1:0]      bus_dir,
  input  logic [1:0]      bus_size,
  input  logic [DW-1:0]   bus_data,
  output logic            hit,
  output logic            post_sel
);
  localparam logic [SELW-1:0] S_ASID = SELW'(BASE + OFS_ASID);
  localparam logic [SELW-1:0] S_ADDR = SELW'(BASE + OFS_ADDR);
  localparam logic [SELW-1:0] S_MASK = SELW'(BASE + OFS_MASK);
  localparam logic [SELW-1:0] S_COND = SELW'(BASE + OFS_COND);

  logic [IW-1:0] asid_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    mask_q;
  cond_t         cond_q;
  logic          asid_ok, addr_ok, cond_ok, data_ok;

  function automatic logic addr_eq(input logic [AW-1:0] a, input logic [AW-1:0] r,
                                   input logic [1:0] code);
    logic [AW-1:0] keep;
    keep = '1;
    case (code)
      2'b01:   keep = {AW{1'b1}} << MASK1_LSBS;
      2'b10:   keep = {AW{1'b1}} << MASK2_LSBS;
      default: keep = '1;
    endcase
    return ((a ^ r) & keep) == '0;
  endfunction

  function automatic logic cond_eq(input cond_t c, input logic [1:0] k,
                                   input logic [1:0] d, input logic [1:0] s);
    logic k_ok, d_ok, s_ok;
    k_ok = (c.kind == k) && (c.kind == KIND_FETCH || c.kind == KIND_DATA);
    d_ok = (c.dir == d) && (c.dir == DIR_RD || c.dir == DIR_WR);
    s_ok = (c.size == SZ_ANY) || (c.size == s);
    return k_ok && d_ok && s_ok;
  endfunction

  function automatic logic data_eq(input logic [DW-1:0] d, input logic [DW-1:0] r,
                                   input logic [DW-1:0] m, input logic [1:0] s);
    logic [DW-1:0] lanes;
    lanes = '1;
    if (s == SZ_BYTE)      lanes = DW'({8{1'b1}});
    else if (s == SZ_WORD) lanes = DW'({16{1'b1}});
    return ((d ^ r) & ~m & lanes) == '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asid_q <= '0;
      addr_q <= '0;
      mask_q <= '0;
      cond_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == S_ASID) asid_q <= cfg_wdata[IW-1:0];
      if (cfg_sel == S_ADDR) addr_q <= cfg_wdata[AW-1:0];
      if (cfg_sel == S_MASK) mask_q <= cfg_wdata[1:0];
      if (cfg_sel == S_COND) cond_q <= cond_t'(cfg_wdata[6:0]);
    end
  end

  generate
    if (HAS_DATA) begin : g_data
      logic [DW-1:0] dval_q, dmask_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dval_q  <= '0;
          dmask_q <= '0;
        end else if (cfg_we) begin
          if (cfg_sel == SELW'(SEL_BDATA))  dval_q  <= cfg_wdata;
          if (cfg_sel == SELW'(SEL_BDMASK)) dmask_q <= cfg_wdata;
        end
      end
      assign data_ok = !(dbe && bus_kind == KIND_DATA) ||
                       data_eq(bus_data, dval_q, dmask_q, bus_size);
    end else begin : g_nodata
      logic unused_data;
      assign unused_data = ^{bus_data, dbe};
      assign data_ok = 1'b1;
    end
  endgenerate

  assign asid_ok  = (bus_asid == asid_q);
  assign addr_ok  = addr_eq(bus_addr, addr_q, mask_q);
  assign cond_ok  = cond_eq(cond_q, bus_kind, bus_dir, bus_size);
  assign hit      = bus_valid && asid_ok && addr_ok && cond_ok && data_ok;
  assign post_sel = cond_q.post && (cond_q.kind == KIND_FETCH);
endmodule

// File: rtl/brk_evt.sv
module brk_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic post_sel,
  input  logic insn_done,
  output logic ev,
  output logic fire
);
  logic pend_q, fire_q, pre_ev;

  assign pre_ev = hit && !post_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= pend_q && insn_done;
      pend_q <= (pend_q && !insn_done) || (hit && post_sel);
    end
  end

  assign fire = fire_q;
  assign ev   = pre_ev || fire_q;
endmodule

// File: rtl/brk_watch.sv
module brk_watch
  import brk_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int IW         = 8,
  parameter int SELW       = 4,
  parameter int MASK1_LSBS = 10,
  parameter int MASK2_LSBS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            bus_valid,
  input  logic [AW-1:0]   bus_addr,
  input  logic [IW-1:0]   bus_asid,
  input  logic [1:0]      bus_kind,
  input  logic [1:0]      bus_dir,
  input  logic [1:0]      bus_size,
  input  logic [DW-1:0]   bus_data,
  input  logic            insn_done,
  output logic            brk_req
);
  localparam int NCH = 2;

  logic [1:0]     ctrl_q;
  logic           seq_mode, dbe, ctrl_wr, armed_q;
  logic [NCH-1:0] hit_v, post_v, ev_v, fire_v;

  assign ctrl_wr  = cfg_we && (cfg_sel == SELW'(SEL_CTRL));
  assign seq_mode = ctrl_q[CTRL_SEQ_BIT];
  assign dbe      = ctrl_q[CTRL_DBE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= cfg_wdata[1:0];
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      brk_chan #(
        .AW(AW), .DW(DW), .IW(IW), .SELW(SELW),
        .BASE(SEL_CHAN0 + g * CHAN_STRIDE),
        .HAS_DATA(g == NCH - 1),
        .MASK1_LSBS(MASK1_LSBS), .MASK2_LSBS(MASK2_LSBS)
      ) u_chan (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dbe(dbe), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_asid(bus_asid), .bus_kind(bus_kind),
        .bus_dir(bus_dir), .bus_size(bus_size), .bus_data(bus_data),
        .hit(hit_v[g]), .post_sel(post_v[g])
      );
      brk_evt u_evt (
        .clk(clk), .rst_n(rst_n), .hit(hit_v[g]), .post_sel(post_v[g]),
        .insn_done(insn_done), .ev(ev_v[g]), .fire(fire_v[g])
      );
    end
  endgenerate

  assign brk_req = seq_mode ? (ev_v[1] && armed_q) : (ev_v[0] || ev_v[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      armed_q <= 1'b0;
    else if (ctrl_wr)                armed_q <= 1'b0;
    else if (seq_mode && brk_req)    armed_q <= 1'b0;
    else if (seq_mode && ev_v[0])    armed_q <= 1'b1;
  end
endmodule

// File: rtl/brk_watch_chk.sv
module brk_watch_chk #(
  parameter int SELW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [SELW-1:0] cfg_sel,
  input logic            insn_done,
  input logic            bus_valid,
  input logic            brk_req,
  input logic            seq_mode,
  input logic            armed_q,
  input logic [1:0]      hit_v,
  input logic [1:0]      ev_v,
  input logic [1:0]      fire_v
);
  // R10
  seq_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && brk_req) |-> armed_q);

  // R11
  break_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && brk_req) |=> !armed_q);

  // R11
  ctrl_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == '0) |=> !armed_q);

  // R8
  post_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire_v) |-> $past(insn_done));

  // R3
  hit_needs_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_v) |-> bus_valid);

  // R9
  indep_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_mode && (|ev_v)) |-> brk_req);
endmodule

bind brk_watch brk_watch_chk #(.SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .insn_done(insn_done), .bus_valid(bus_valid), .brk_req(brk_req),
  .seq_mode(seq_mode), .armed_q(armed_q), .hit_v(hit_v), .ev_v(ev_v),
  .fire_v(fire_v)
);

// File: tb/brk_watch_test.sv
module brk_watch_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [7:0]  bus_asid = '0;
  logic [1:0]  bus_kind = '0, bus_dir = '0, bus_size = '0;
  logic [31:0] bus_data = '0;
  logic        insn_done = 1'b0;
  logic        brk_req;

  int n_chk = 0, n_bad = 0;

  logic [1:0]  s_ctrl;
  logic [7:0]  s_asid [2];
  logic [31:0] s_addr [2];
  logic [1:0]  s_mask [2];
  logic [6:0]  s_cond [2];
  logic [31:0] s_bdat, s_bdm;
  logic        m_pend [2];
  logic        m_fire [2];
  logic        m_armed;

  always #(CLK_PERIOD / 2) clk = ~clk;

  brk_watch uut (.*);

  function automatic logic b_addr(input logic [31:0] a, input logic [31:0] r, input logic [1:0] c);
    int n;
    n = (c == 2'd1) ? 10 : (c == 2'd2) ? 12 : 0;
    return (a >> n) == (r >> n);
  endfunction

  function automatic logic b_cond(input logic [5:0] c, input logic [1:0] k,
                                  input logic [1:0] d, input logic [1:0] s);
    logic ko, dk, so;
    ko = (c[5:4] == k) && (k == 2'd1 || k == 2'd2);
    dk = (c[3:2] == d) && (d == 2'd1 || d == 2'd2);
    so = (c[1:0] == 2'd0) || (c[1:0] == s);
    return ko && dk && so;
  endfunction

  function automatic logic b_data(input logic [31:0] d, input logic [31:0] r,
                                  input logic [31:0] m, input logic [1:0] s);
    int w;
    w = (s == 2'd1) ? 8 : (s == 2'd2) ? 16 : 32;
    for (int j = 0; j < w; j++)
      if (!m[j] && d[j] != r[j]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s brk_req=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_clear();
    s_ctrl = '0; s_bdat = '0; s_bdm = '0; m_armed = 1'b0;
    for (int i = 0; i < 2; i++) begin
      s_asid[i] = '0; s_addr[i] = '0; s_mask[i] = '0; s_cond[i] = '0;
      m_pend[i] = 1'b0; m_fire[i] = 1'b0;
    end
  endtask

  task automatic cyc(input logic we, input logic [3:0] sel, input logic [31:0] wd,
                     input logic v, input logic [31:0] a, input logic [7:0] id,
                     input logic [1:0] k, input logic [1:0] d, input logic [1:0] s,
                     input logic [31:0] dt, input logic dn, input string tag);
    logic h [2];
    logic p [2];
    logic e [2];
    logic want;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd; bus_valid = v; bus_addr = a;
    bus_asid = id; bus_kind = k; bus_dir = d; bus_size = s; bus_data = dt;
    insn_done = dn;
    #1;
    for (int i = 0; i < 2; i++) begin
      h[i] = v && (id == s_asid[i]) && b_addr(a, s_addr[i], s_mask[i]) &&
             b_cond(s_cond[i][5:0], k, d, s) &&
             (i == 0 || !(s_ctrl[1] && k == 2'd2) || b_data(dt, s_bdat, s_bdm, s));
      p[i] = s_cond[i][6] && (s_cond[i][5:4] == 2'd1);
      e[i] = (h[i] && !p[i]) || m_fire[i];
    end
    want = s_ctrl[0] ? (e[1] && m_armed) : (e[0] || e[1]);
    check(tag, brk_req, want);
    if (we && sel == 4'd0)        m_armed = 1'b0;
    else if (s_ctrl[0] && want)   m_armed = 1'b0;
    else if (s_ctrl[0] && e[0])   m_armed = 1'b1;
    for (int i = 0; i < 2; i++) begin
      m_fire[i] = m_pend[i] && dn;
      m_pend[i] = (m_pend[i] && !dn) || (h[i] && p[i]);
    end
    if (we) begin
      case (sel)
        4'd0: s_ctrl = wd[1:0];
        4'd1: s_asid[0] = wd[7:0];
        4'd2: s_addr[0] = wd;
        4'd3: s_mask[0] = wd[1:0];
        4'd4: s_cond[0] = wd[6:0];
        4'd5: s_asid[1] = wd[7:0];
        4'd6: s_addr[1] = wd;
        4'd7: s_mask[1] = wd[1:0];
        4'd8: s_cond[1] = wd[6:0];
        4'd9: s_bdat = wd;
        4'd10: s_bdm = wd;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [31:0] val);
    cyc(1'b1, sel, val, 1'b0, '0, '0, '0, '0, '0, '0, 1'b0, "R2 write");
  endtask

  task automatic bc(input logic [31:0] a, input logic [7:0] id, input logic [1:0] k,
                    input logic [1:0] d, input logic [1:0] s, input logic [31:0] dt,
                    input logic dn, input string tag);
    cyc(1'b0, 4'd0, '0, 1'b1, a, id, k, d, s, dt, dn, tag);
  endtask

  task automatic idle(input logic dn, input string tag);
    cyc(1'b0, 4'd0, '0, 1'b0, '0, '0, '0, '0, '0, '0, dn, tag);
  endtask

  function automatic logic [31:0] pick4(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c, input logic [31:0] d);
    case ($urandom_range(0, 3))
      0: return a;
      1: return b;
      2: return c;
      default: return d;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_clear();
    rst_n = 1'b0;
    bus_valid = 1'b1; bus_kind = 2'd1; bus_dir = 2'd1;
    repeat (3) @(negedge clk);
    check("R1 in reset", brk_req, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared registers never match
    bc(32'h0, 8'h00, 2'd1, 2'd1, 2'd0, '0, 1'b0, "R1 fetch after reset");
    bc(32'h0, 8'h00, 2'd2, 2'd2, 2'd2, '0, 1'b1, "R1 data after reset");
    idle(1'b0, "R1 idle");

    // R2: write and matching cycle together -> old condition used
    wr(4'd1, 32'h80);
    wr(4'd2, 32'h00037226);
    cyc(1'b1, 4'd4, 32'h16, 1'b1, 32'h00037226, 8'h80, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R2 same-cycle write");
    bc(32'h00037226, 8'h80, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R7 pre fetch hit");
    bc(32'h00037226, 8'h70, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R3 asid mismatch");
    bc(32'h00037226, 8'h80, 2'd1, 2'd1, 2'd3, '0, 1'b0, "R5 size mismatch");
    bc(32'h00037226, 8'h80, 2'd2, 2'd1, 2'd2, '0, 1'b0, "R5 class mismatch");
    bc(32'h00037226, 8'h80, 2'd1, 2'd2, 2'd2, '0, 1'b0, "R5 direction mismatch");
    bc(32'h00037227, 8'h80, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R4 code 00 full compare");

    // R4: masked windows
    wr(4'd2, 32'h00008000);
    wr(4'd3, 32'h1);
    bc(32'h000083FE, 8'h80, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R4 code 01 inside");
    bc(32'h00008400, 8'h80, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R4 code 01 outside");
    wr(4'd3, 32'h2);
    bc(32'h00008FFC, 8'h80, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R4 code 10 inside");
    bc(32'h00009000, 8'h80, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R4 code 10 outside");
    wr(4'd3, 32'h3);
    bc(32'h00008002, 8'h80, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R4 code 11 full compare");
    wr(4'd3, 32'h0);

    // R8: post-execution fetch
    wr(4'd4, 32'h56);
    bc(32'h00008000, 8'h80, 2'd1, 2'd1, 2'd2, '0, 1'b1, "R8 match with same-cycle done");
    idle(1'b0, "R8 waiting");
    idle(1'b1, "R8 done strobe");
    idle(1'b0, "R8 post break");
    idle(1'b0, "R8 single pulse");

    // R6: channel B data compare
    wr(4'd4, 32'h0);
    wr(4'd5, 32'h70);
    wr(4'd6, 32'h000ABCDE);
    wr(4'd8, 32'h2A);
    wr(4'd9, 32'h0000A512);
    wr(4'd0, 32'h2);
    bc(32'h000ABCDE, 8'h70, 2'd2, 2'd2, 2'd2, 32'h1234A512, 1'b0, "R6 word ignores upper");
    bc(32'h000ABCDE, 8'h70, 2'd2, 2'd2, 2'd2, 32'h0000A513, 1'b0, "R6 data mismatch");
    wr(4'd10, 32'h1);
    bc(32'h000ABCDE, 8'h70, 2'd2, 2'd2, 2'd2, 32'h0000A513, 1'b0, "R6 masked bit");
    wr(4'd0, 32'h0);
    bc(32'h000ABCDE, 8'h70, 2'd2, 2'd2, 2'd2, 32'hFFFFFFFF, 1'b0, "R6 compare disabled");
    wr(4'd8, 32'h69);
    bc(32'h000ABCDE, 8'h70, 2'd2, 2'd2, 2'd1, 32'hFFFFFFFF, 1'b0, "R7 data post bit ignored");

    // R10 / R11: sequential mode
    wr(4'd4, 32'h14);
    wr(4'd2, 32'h00037226);
    wr(4'd8, 32'h16);
    wr(4'd6, 32'h0003722E);
    wr(4'd0, 32'h1);
    bc(32'h0003722E, 8'h70, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R10 B before A ignored");
    bc(32'h00037226, 8'h80, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R10 A arms only");
    bc(32'h0003722E, 8'h70, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R10 B after A breaks");
    bc(32'h0003722E, 8'h70, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R11 cleared by break");
    bc(32'h00037226, 8'h80, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R10 re-arm");
    wr(4'd0, 32'h1);
    bc(32'h0003722E, 8'h70, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R11 cleared by control write");
    wr(4'd0, 32'h0);
    bc(32'h00037226, 8'h80, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R9 independent A");
    bc(32'h0003722E, 8'h70, 2'd1, 2'd1, 2'd2, '0, 1'b0, "R9 independent B");

    // mixed random traffic
    for (int t = 0; t < 6000; t++) begin
      if ($urandom_range(0, 15) == 0) begin
        logic [3:0] sel;
        logic [31:0] val;
        sel = 4'($urandom_range(0, 10));
        case (sel)
          4'd0: val = 32'($urandom_range(0, 3));
          4'd1, 4'd5: val = pick4(32'h80, 32'h70, 32'h80, 32'h70);
          4'd2, 4'd6: val = pick4(32'h00037226, 32'h0003722E, 32'h000ABCDE, 32'h00008000);
          4'd3, 4'd7: val = 32'($urandom_range(0, 3));
          4'd4, 4'd8: val = pick4(32'h14, 32'h56, 32'h24, 32'h2A) ^ pick4(0, 0, 32'h40, 32'h02);
          4'd9: val = pick4(32'h0000A512, 32'h1234A512, 32'h0, 32'h000000AB);
          default: val = pick4(32'h0, 32'h1, 32'hFFFF0000, $urandom);
        endcase
        cyc(1'b1, sel, val, 1'b0, '0, '0, '0, '0, '0, '0, ($urandom_range(0, 2) == 0),
            "R2 random write");
      end else begin
        int i;
        logic [31:0] a, dt;
        logic [7:0] id;
        logic [1:0] k, d, s;
        i  = $urandom_range(0, 1);
        a  = s_addr[i] ^ (($urandom_range(0, 2) == 0) ? 32'h0 : ($urandom & 32'h00001FFF));
        id = ($urandom_range(0, 4) != 0) ? s_asid[i] : 8'($urandom);
        k  = ($urandom_range(0, 3) != 0) ? s_cond[i][5:4] : 2'($urandom);
        d  = ($urandom_range(0, 3) != 0) ? s_cond[i][3:2] : 2'($urandom);
        s  = 2'($urandom_range(1, 3));
        dt = s_bdat ^ (($urandom_range(0, 1) == 0) ? 32'h0 : (32'h1 << $urandom_range(0, 31)));
        cyc(1'b0, 4'd0, '0, ($urandom_range(0, 4) != 0), a, id, k, d, s, dt,
            ($urandom_range(0, 2) == 0), "R9 R10 R8 R6 random");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule